// File: doc/BRIEF.md
# Scroll and VRAM Address Register Unit

This block holds the scroll and video-memory address state of a tile-based video processor and serves the CPU side of it. Scroll is not kept as separate X and Y values. It lives in a packed 15-bit pending address and a 3-bit fine horizontal offset. CPU writes to the control, scroll and address ports set bit fields of the pending address, and a single write-phase flag decides which half a scroll or address write fills. The pending address reaches the live address in two ways. A completed address-port pair copies all of it at once. Commands from the rendering side copy it in a horizontal part and a vertical part.

The live address drives the video-memory address bus. Each CPU data-port access advances it by 1 or by 32. Reads below the palette window go through a one-deep delayed buffer. Reads inside that window come straight from memory. The fetch sequencer can load the live address with values it computes itself, for its coarse-X and Y steps. When a rendering command and a CPU update fall in the same cycle, the rendering command wins.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset the live address, pending address, fine X, write-phase flag, increment mode and read buffer are all zero.
- R2: A control-port write (port select 0) sets pending bits 11:10 from data bits 1:0. It leaves the other pending bits unchanged and sets the increment mode from data bit 2.
- R3: A scroll-port write (select 1) with the phase flag clear sets pending bits 4:0 from data 7:3 and fine X from data 2:0, then sets the flag.
- R4: A scroll-port write with the phase flag set loads pending bits 9:5 from data 7:3 and bits 14:12 from data 2:0, then clears the flag. Fine X changes only through R3.
- R5: An address-port write (select 2) with the flag clear loads pending bits 13:8 from data 5:0 and clears bit 14. With the flag set it loads pending bits 7:0 from the data, copies the whole updated pending value into the live address, and toggles the flag.
- R6: The scroll and address ports share the phase flag. A status-port read (select 4) clears it and returns 0.
- R7: A data-port access (select 3) advances the live address by 32 when increment mode is 1, otherwise by 1. The sum wraps within 14 bits and bit 14 becomes 0. The memory address is the live address bits 13:0, and a data write drives the write strobe with the CPU byte.
- R8: A data-port read at an address below 0x3F00 returns the buffered byte and reloads the buffer from memory at the live address.
- R9: A data-port read at 0x3F00 or above returns the memory byte directly and leaves the buffer unchanged.
- R10: With rendering enabled, a horizontal-copy command loads live bits 10 and 4:0 from the pending address.
- R11: With rendering enabled, a vertical-copy command loads live bits 14:11 and 9:5 from the pending address.
- R12: With rendering enabled, a coarse-X or Y step strobe loads the live address from the sequencer's next-address input, and copy commands in the same cycle then overwrite their fields. With rendering disabled, every rendering command is ignored.
- R13: In a cycle with an enabled rendering command, CPU updates of the live address (data-port step, address-pair load) are dropped. Pending-address, flag and buffer updates still happen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_sel | input | 3 | Port select: 0 control, 1 scroll, 2 address, 3 data, 4 status |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, valid in the cycle of the read |
| mem_addr | output | 14 | Video-memory address |
| mem_rdata | input | 8 | Video-memory read byte for mem_addr, same cycle |
| mem_we | output | 1 | Video-memory write strobe |
| mem_wdata | output | 8 | Video-memory write byte |
| rnd_enable | input | 1 | Rendering enabled |
| rnd_hcopy | input | 1 | Horizontal-copy command |
| rnd_vcopy | input | 1 | Vertical-copy command |
| rnd_xstep | input | 1 | Coarse-X step strobe |
| rnd_ystep | input | 1 | Y step strobe |
| rnd_v_next | input | 15 | Live address computed by the fetch sequencer for a step |
| vaddr | output | 15 | Full live address |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The assertions assume that the CPU never raises the read and write strobes in the same cycle. They also assume that a step strobe comes with a meaningful next-address value. The bench keeps to both. It drives exactly one CPU operation or none per cycle and supplies arbitrary but defined next-address values. Memory read data is a fixed function of the address, so the reference model can predict the delayed-buffer contents. Directed sequences hit the phase-flag corners, the 14-bit wrap and the palette boundary. A long mixed sequence then combines CPU traffic with enabled and disabled rendering commands in the same cycles.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
    localparam int ADDR_W = 15;
    localparam int MEM_W  = 14;
    localparam int DATA_W = 8;
    localparam int FX_W   = 3;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_SCROLL = 3'd1,
        SEL_ADDR   = 3'd2,
        SEL_DATA   = 3'd3,
        SEL_STATUS = 3'd4
    } port_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] v;
        logic [ADDR_W-1:0] t;
        logic [FX_W-1:0]   fx;
        logic              tog;
        logic              inc32;
        logic [DATA_W-1:0] rbuf;
    } regs_t;
endpackage

// File: rtl/pending_addr_logic.sv
module pending_addr_logic
    import scroll_pkg::*;
(
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [2:0]        cpu_sel,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] t_q,
    input  logic [FX_W-1:0]   fx_q,
    input  logic              tog_q,
    input  logic              inc32_q,
    output logic [ADDR_W-1:0] t_d,
    output logic [FX_W-1:0]   fx_d,
    output logic              tog_d,
    output logic              inc32_d,
    output logic              full_load,
    output logic [ADDR_W-1:0] load_val
);
    always_comb begin
        t_d       = t_q;
        fx_d      = fx_q;
        tog_d     = tog_q;
        inc32_d   = inc32_q;
        full_load = 1'b0;
        if (cpu_wr) begin
            case (cpu_sel)
                SEL_CTRL: begin
                    t_d[11:10] = cpu_wdata[1:0];
                    inc32_d    = cpu_wdata[2];
                end
                SEL_SCROLL: begin
                    if (!tog_q) begin
                        t_d[4:0] = cpu_wdata[7:3];
                        fx_d     = cpu_wdata[2:0];
                    end else begin
                        t_d[9:5]   = cpu_wdata[7:3];
                        t_d[14:12] = cpu_wdata[2:0];
                    end
                    tog_d = ~tog_q;
                end
                SEL_ADDR: begin
                    if (!tog_q) begin
                        t_d[13:8] = cpu_wdata[5:0];
                        t_d[14]   = 1'b0;
                    end else begin
                        t_d[7:0]  = cpu_wdata;
                        full_load = 1'b1;
                    end
                    tog_d = ~tog_q;
                end
                default: ;
            endcase
        end else if (cpu_rd && cpu_sel == SEL_STATUS) begin
            tog_d = 1'b0;
        end
        load_val = t_d;
    end
endmodule

// File: rtl/live_addr_logic.sv
module live_addr_logic
    import scroll_pkg::*;
#(
    parameter int WIDE_STEP = 32
) (
    input  logic [ADDR_W-1:0] v_q,
    input  logic [ADDR_W-1:0] t_q,
    input  logic              inc32_q,
    input  logic              data_acc,
    input  logic              full_load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              rnd_enable,
    input  logic              rnd_hcopy,
    input  logic              rnd_vcopy,
    input  logic              rnd_xstep,
    input  logic              rnd_ystep,
    input  logic [ADDR_W-1:0] rnd_v_next,
    output logic [ADDR_W-1:0] v_d
);
    localparam logic [MEM_W-1:0] STEP_WIDE = MEM_W'(WIDE_STEP);
    localparam logic [MEM_W-1:0] STEP_ONE  = MEM_W'(1);

    logic             rnd_act;
    logic [MEM_W-1:0] stepped;

    always_comb begin
        rnd_act = rnd_enable & (rnd_hcopy | rnd_vcopy | rnd_xstep | rnd_ystep);
        stepped = v_q[MEM_W-1:0] + (inc32_q ? STEP_WIDE : STEP_ONE);
        v_d     = v_q;
        if (rnd_act) begin
            if (rnd_xstep || rnd_ystep) v_d = rnd_v_next;
            if (rnd_hcopy) begin
                v_d[10]  = t_q[10];
                v_d[4:0] = t_q[4:0];
            end
            if (rnd_vcopy) begin
                v_d[14:11] = t_q[14:11];
                v_d[9:5]   = t_q[9:5];
            end
        end else if (full_load) begin
            v_d = load_val;
        end else if (data_acc) begin
            v_d = {1'b0, stepped};
        end
    end
endmodule

// File: rtl/read_path.sv
module read_path
    import scroll_pkg::*;
#(
    parameter logic [13:0] PAL_BASE = 14'h3F00
) (
    input  logic              cpu_rd,
    input  logic [2:0]        cpu_sel,
    input  logic [ADDR_W-1:0] v_q,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] rbuf_q,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rbuf_d
);
    logic in_pal;

    always_comb begin
        in_pal = (v_q[MEM_W-1:0] >= PAL_BASE);
        rdata  = '0;
        rbuf_d = rbuf_q;
        if (cpu_rd && cpu_sel == SEL_DATA) begin
            if (in_pal) begin
                rdata = mem_rdata;
            end else begin
                rdata  = rbuf_q;
                rbuf_d = mem_rdata;
            end
        end
    end
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
    import scroll_pkg::*;
#(
    parameter int          WIDE_STEP = 32,
    parameter logic [13:0] PAL_BASE  = 14'h3F00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [2:0]  cpu_sel,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic [13:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    input  logic        rnd_enable,
    input  logic        rnd_hcopy,
    input  logic        rnd_vcopy,
    input  logic        rnd_xstep,
    input  logic        rnd_ystep,
    input  logic [14:0] rnd_v_next,
    output logic [14:0] vaddr,
    output logic [2:0]  fine_x
);
    regs_t r_q, r_d;

    logic [ADDR_W-1:0] t_d, v_d, load_val;
    logic [FX_W-1:0]   fx_d;
    logic              tog_d, inc32_d, full_load, data_acc;
    logic [DATA_W-1:0] rbuf_d, rdata;
    logic              rnd_act;

    assign data_acc = (cpu_wr || cpu_rd) && cpu_sel == SEL_DATA;
    assign rnd_act  = rnd_enable && (rnd_hcopy || rnd_vcopy || rnd_xstep || rnd_ystep);

    pending_addr_logic u_pending (
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .t_q       (r_q.t),
        .fx_q      (r_q.fx),
        .tog_q     (r_q.tog),
        .inc32_q   (r_q.inc32),
        .t_d       (t_d),
        .fx_d      (fx_d),
        .tog_d     (tog_d),
        .inc32_d   (inc32_d),
        .full_load (full_load),
        .load_val  (load_val)
    );

    live_addr_logic #(.WIDE_STEP(WIDE_STEP)) u_live (
        .v_q        (r_q.v),
        .t_q        (r_q.t),
        .inc32_q    (r_q.inc32),
        .data_acc   (data_acc),
        .full_load  (full_load),
        .load_val   (load_val),
        .rnd_enable (rnd_enable),
        .rnd_hcopy  (rnd_hcopy),
        .rnd_vcopy  (rnd_vcopy),
        .rnd_xstep  (rnd_xstep),
        .rnd_ystep  (rnd_ystep),
        .rnd_v_next (rnd_v_next),
        .v_d        (v_d)
    );

    read_path #(.PAL_BASE(PAL_BASE)) u_read (
        .cpu_rd    (cpu_rd),
        .cpu_sel   (cpu_sel),
        .v_q       (r_q.v),
        .mem_rdata (mem_rdata),
        .rbuf_q    (r_q.rbuf),
        .rdata     (rdata),
        .rbuf_d    (rbuf_d)
    );

    always_comb begin
        r_d       = r_q;
        r_d.v     = v_d;
        r_d.t     = t_d;
        r_d.fx    = fx_d;
        r_d.tog   = tog_d;
        r_d.inc32 = inc32_d;
        r_d.rbuf  = rbuf_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_rdata = rdata;
    assign mem_addr  = r_q.v[MEM_W-1:0];
    assign mem_we    = cpu_wr && cpu_sel == SEL_DATA;
    assign mem_wdata = cpu_wdata;
    assign vaddr     = r_q.v;
    assign fine_x    = r_q.fx;

    AST_CTRL_NT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == SEL_CTRL) |=> (r_q.t[11:10] == $past(cpu_wdata[1:0]))
            && (r_q.t[14:12] == $past(r_q.t[14:12])) && (r_q.t[9:0] == $past(r_q.t[9:0]))); // R2
    AST_FINEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_sel == SEL_SCROLL && !r_q.tog) |=> $stable(r_q.fx)); // R4
    AST_STATUS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel == SEL_STATUS) |=> !r_q.tog); // R6
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == SEL_ADDR && r_q.tog && !rnd_act)
            |=> r_q.v == {$past(r_q.t[14:8]), $past(cpu_wdata)}); // R5
    AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !rnd_act) |=> !r_q.v[14] && (r_q.v[13:0] ==
            $past(r_q.v[13:0]) + ($past(r_q.inc32) ? 14'd32 : 14'd1))); // R7
    AST_HCOPY: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_enable && rnd_hcopy) |=> (r_q.v[10] == $past(r_q.t[10]))
            && (r_q.v[4:0] == $past(r_q.t[4:0]))); // R10
    AST_VCOPY: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_enable && rnd_vcopy) |=> (r_q.v[14:11] == $past(r_q.t[14:11]))
            && (r_q.v[9:5] == $past(r_q.t[9:5]))); // R11
    AST_STEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_enable && (rnd_xstep || rnd_ystep) && !rnd_hcopy && !rnd_vcopy)
            |=> r_q.v == $past(rnd_v_next)); // R13
    AST_RND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rnd_enable && !data_acc && !(cpu_wr && cpu_sel == SEL_ADDR)) |=> $stable(r_q.v)); // R12
    AST_PAL_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel == SEL_DATA && r_q.v[13:0] >= PAL_BASE) |=> $stable(r_q.rbuf)); // R9
endmodule

// File: tb/scroll_addr_unit_bench.sv
module scroll_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0]  cpu_sel = 3'd0;
    logic [7:0]  cpu_wdata = 8'd0;
    logic [7:0]  cpu_rdata, mem_rdata, mem_wdata;
    logic [13:0] mem_addr;
    logic        mem_we;
    logic        rnd_enable = 1'b0, rnd_hcopy = 1'b0, rnd_vcopy = 1'b0;
    logic        rnd_xstep = 1'b0, rnd_ystep = 1'b0;
    logic [14:0] rnd_v_next = 15'd0;
    logic [14:0] vaddr;
    logic [2:0]  fine_x;

    int n_cmp = 0, n_bad = 0;

    // Reference state
    int m_v, m_t, m_fx, m_tog, m_inc, m_buf;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b01};
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    scroll_addr_unit u_scroll_addr_unit (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .rnd_enable(rnd_enable), .rnd_hcopy(rnd_hcopy),
        .rnd_vcopy(rnd_vcopy), .rnd_xstep(rnd_xstep), .rnd_ystep(rnd_ystep),
        .rnd_v_next(rnd_v_next), .vaddr(vaddr), .fine_x(fine_x)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic cyc(input string tag, input bit wr, input bit rd, input int sel,
                       input int d, input bit en, input bit hc, input bit vc,
                       input bit xs, input bit ys, input int vn);
        int nv, nt, nfx, ntog, ninc, nbuf, exp_rd;
        bit load, acc, ract;
        @(negedge clk);
        cpu_wr = wr; cpu_rd = rd; cpu_sel = 3'(sel); cpu_wdata = 8'(d);
        rnd_enable = en; rnd_hcopy = hc; rnd_vcopy = vc;
        rnd_xstep = xs; rnd_ystep = ys; rnd_v_next = 15'(vn);
        #1;
        nv = m_v; nt = m_t; nfx = m_fx; ntog = m_tog; ninc = m_inc; nbuf = m_buf;
        load = 0; acc = 0; exp_rd = 0;
        if (wr) begin
            if (sel == 0) begin
                nt = (nt & ~32'h0C00) | ((d & 3) << 10);
                ninc = (d >> 2) & 1;
            end else if (sel == 1) begin
                if (m_tog == 0) begin
                    nt = (nt & ~32'h1F) | ((d >> 3) & 32'h1F);
                    nfx = d & 7;
                end else begin
                    nt = (nt & ~32'h73E0) | (((d >> 3) & 32'h1F) << 5) | ((d & 7) << 12);
                end
                ntog = 1 - m_tog;
            end else if (sel == 2) begin
                if (m_tog == 0) nt = (nt & 32'h00FF) | ((d & 32'h3F) << 8);
                else begin
                    nt = (nt & 32'h7F00) | (d & 32'hFF);
                    load = 1;
                end
                ntog = 1 - m_tog;
            end else if (sel == 3) acc = 1;
        end else if (rd) begin
            if (sel == 4) ntog = 0;
            if (sel == 3) begin
                acc = 1;
                if ((m_v & 32'h3FFF) < 32'h3F00) begin
                    exp_rd = m_buf;
                    nbuf = mem_fn(14'(m_v));
                end else exp_rd = mem_fn(14'(m_v));
            end
        end
        ract = en && (hc || vc || xs || ys);
        if (ract) begin
            if (xs || ys) nv = vn;
            if (hc) nv = (nv & ~32'h041F) | (m_t & 32'h041F);
            if (vc) nv = (nv & ~32'h7BE0) | (m_t & 32'h7BE0);
        end else if (load) nv = nt;
        else if (acc) nv = (m_v + (m_inc ? 32 : 1)) & 32'h3FFF;
        cmp(tag, "vaddr", int'(vaddr), m_v);
        cmp(tag, "fine_x", int'(fine_x), m_fx);
        cmp(tag, "mem_addr", int'(mem_addr), m_v & 32'h3FFF);
        cmp(tag, "mem_we", int'(mem_we), (wr && sel == 3) ? 1 : 0);
        if (wr && sel == 3) cmp(tag, "mem_wdata", int'(mem_wdata), d & 32'hFF);
        if (rd) cmp(tag, "cpu_rdata", int'(cpu_rdata), exp_rd);
        @(posedge clk);
        m_v = nv; m_t = nt; m_fx = nfx; m_tog = ntog; m_inc = ninc; m_buf = nbuf;
    endtask

    task automatic wr_(input string tag, input int sel, input int d);
        cyc(tag, 1, 0, sel, d, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rd_(input string tag, input int sel);
        cyc(tag, 0, 1, sel, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_v = 0; m_t = 0; m_fx = 0; m_tog = 0; m_inc = 0; m_buf = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        idle("R1");                       // R1 reset state
        rd_("R1", 3);                     // R1 buffer starts at zero
        // R2 control write, R3/R4 scroll pair, R5 address pair
        wr_("R2", 0, 8'h07);
        wr_("R3", 1, 8'hAD);
        wr_("R4", 1, 8'h5E);
        wr_("R4", 0, 8'h02);              // R4 fine X unchanged by control
        wr_("R5", 2, 8'hFF);
        wr_("R5", 2, 8'h3C);
        idle("R5");
        // R6 status clears phase flag mid-pair
        wr_("R6", 1, 8'h13);
        rd_("R6", 4);
        wr_("R6", 1, 8'hF1);              // acts as first write again
        rd_("R6", 4);
        // R7 increment 1 and wrap at top of 14-bit range
        wr_("R7", 0, 8'h00);
        wr_("R7", 2, 8'h3F); wr_("R7", 2, 8'hFF);
        wr_("R7", 3, 8'h55);
        wr_("R7", 3, 8'h66);
        // R7 increment 32 with wrap
        wr_("R7", 0, 8'h04);
        wr_("R7", 2, 8'h3F); wr_("R7", 2, 8'hF0);
        rd_("R9", 3);                     // R9 palette read direct
        rd_("R7", 3);
        // R8 buffered reads
        wr_("R8", 0, 8'h00);
        wr_("R8", 2, 8'h21); wr_("R8", 2, 8'h05);
        rd_("R8", 3); rd_("R8", 3); rd_("R8", 3);
        // R9 boundary: 0x3EFF then 0x3F00, buffer kept
        wr_("R9", 2, 8'h3E); wr_("R9", 2, 8'hFF);
        rd_("R9", 3); rd_("R9", 3); rd_("R9", 3);
        wr_("R9", 2, 8'h10); wr_("R9", 2, 8'h00);
        rd_("R9", 3);
        // R10/R11 copies
        wr_("R10", 1, 8'hFF); wr_("R10", 1, 8'hFF); wr_("R10", 0, 8'h03);
        cyc("R10", 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        cyc("R11", 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        idle("R11");
        // R12 steps, disabled commands ignored
        cyc("R12", 0, 0, 0, 0, 1, 0, 0, 1, 0, 15'h1234);
        cyc("R12", 0, 0, 0, 0, 1, 0, 0, 0, 1, 15'h5A5A);
        cyc("R12", 0, 0, 0, 0, 0, 1, 1, 1, 1, 15'h0001);
        cyc("R12", 0, 0, 0, 0, 1, 1, 0, 1, 0, 15'h7FFF);
        idle("R12");
        // R13 render wins over data access and address load
        cyc("R13", 1, 0, 3, 8'h99, 1, 0, 0, 1, 0, 15'h0ABC);
        cyc("R13", 0, 1, 3, 0, 1, 0, 0, 0, 1, 15'h0100);
        wr_("R13", 2, 8'h12);
        cyc("R13", 1, 0, 2, 8'h34, 1, 0, 0, 1, 0, 15'h2222);
        idle("R13");
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 9);
            int s  = $urandom_range(0, 4);
            int dd = $urandom_range(0, 255);
            bit en = ($urandom_range(0, 3) == 0);
            bit hc = $urandom_range(0, 1), vc = ($urandom_range(0, 3) == 0);
            bit xs = $urandom_range(0, 1), ys = ($urandom_range(0, 3) == 0);
            int vn = $urandom_range(0, 32767);
            if (op < 4)      cyc("R13", 1, 0, s, dd, en, hc, vc, xs, ys, vn);
            else if (op < 8) cyc("R8", 0, 1, s, dd, en, hc, vc, xs, ys, vn);
            else             cyc("R12", 0, 0, s, dd, en, hc, vc, xs, ys, vn);
        end
        idle("R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule